// File: doc/BRIEF.md
# ACPI Sleep State Controller

This block steps a system between its working state and five sleep depths. Software picks a depth with a 3-bit code and sets a start bit in the same write. The block then asks the SDRAM to enter self-refresh. Once the SDRAM acknowledges, the block gates clocks and drops power rails according to the chosen depth. The outputs it drives are enables and requests toward the clock tree, the PLLs, the SDRAM controller, two power-control pins, an active-low main power-on pin and a status LED. It does not model the PLLs, rails or event sources themselves.

A wake event returns the block to the working state, provided it is enabled both globally and for the current depth. On the way out the block restores the rails, powers the PLLs and holds the core clock gated for a programmable lock window. The two lightest depths resume with all context kept. The three deepest hold a system reset low during that window, so the system runs a power-up sequence. After the window the block drops the self-refresh request and ungates the clocks. It resumes throttled or at full speed, according to the throttle bit.

Top module: `sleepCtl`

## Requirements
- R1: After reset, the block is in the working state. coreClkEn, sysClkEn, pllEn, pwrCtl1, pwrCtl2 and sysRstN are 1. keepClkEn is all ones. selfRefReq, onCtlN, ledOut and throttleOn are 0. The wake enables are all ones and the lock count is 8.
- R2: In the working state, a write to address 0 with bit 3 set and a code of 1 to 5 in bits 2:0 starts entry. selfRefReq goes high on the next clock edge. coreClkEn stays 1 until srAck has been seen high.
- R3: A start write with code 0, 6 or 7, or a write to address 0 with bit 3 clear, leaves every output unchanged and selfRefReq at 0.
- R4: In depth 1, coreClkEn is 0. sysClkEn, pllEn and every keepClkEn bit stay 1. selfRefReq is 1, pwrCtl1 and pwrCtl2 are 1, and onCtlN is 0.
- R5: In depth 2, coreClkEn and sysClkEn are 0 and keepClkEn equals the keep-clock select field. pllEn is 1 exactly when that field is nonzero. pwrCtl1 is 0 while pwrCtl2 stays 1, onCtlN is 0 and selfRefReq is 1. Changing the field during sleep takes effect at once.
- R6: In depth 3, all clock enables, pllEn, pwrCtl1 and pwrCtl2 are 0. onCtlN is 0 and selfRefReq is 1.
- R7: Depths 4 and 5 give identical outputs. These match depth 3 except that onCtlN is 1.
- R8: A wake occurs only when a bit is set in all three of: wakeEvt, the global wake-enable register, and the mask for the current depth. The masks are bits 7:0 for depth 1, 6:0 for depth 2, 3:0 for depth 3, and 1:0 for depths 4 and 5. Any other event has no effect.
- R9: Suppose a wake is sampled on a clock edge with lock count L. Then coreClkEn returns to 1 on the (L+2)-th edge counted from that edge. Until then pllEn, pwrCtl1 and pwrCtl2 are 1, onCtlN is 0 and selfRefReq is 1. When coreClkEn returns, selfRefReq is 0.
- R10: sysRstN is 0 during the lock window when leaving depths 3, 4 and 5, and stays 1 when leaving depths 1 and 2.
- R11: throttleOn takes the value of the throttle bit (address 0, bit 4) in force at the wake edge, and holds it until the next wake.
- R12: In depths 4 and 5, ledOut follows the LED field: 0 is off, 1 is on, 2 is a slow blink toggling every 2^SLOW_BIT rtcTick pulses, and 3 is a fast blink toggling every 2^FAST_BIT pulses. In every other state ledOut is 0.
- R13: The register map is as follows. Address 0 holds the sleep code (bits 2:0), the start bit (bit 3) and the throttle bit (bit 4). Address 1 holds the wake enables in bits WAKE_W-1:0. Address 2 holds the LED field in bits 1:0 and the keep-clock select in bits KEEP_W+3:4. Address 3 holds the lock count in bits LOCK_W-1:0. Each register takes its value on a cycle with regWr high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | DATA_W | Register write data |
| rtcTick | input | 1 | One-cycle pulse at the 32 kHz rate |
| wakeEvt | input | WAKE_W | Wake event sources |
| srAck | input | 1 | SDRAM self-refresh acknowledge |
| coreClkEn | output | 1 | Core, memory and display clock enable |
| sysClkEn | output | 1 | Other system clock enable |
| pllEn | output | 1 | PLL power enable |
| keepClkEn | output | KEEP_W | Selectable clocks kept in depth 2 |
| selfRefReq | output | 1 | SDRAM self-refresh request |
| pwrCtl1 | output | 1 | Power-control pin 1, high is on |
| pwrCtl2 | output | 1 | Power-control pin 2, high is on |
| onCtlN | output | 1 | Main power-on, active low |
| sysRstN | output | 1 | Power-up reset to the system, active low |
| throttleOn | output | 1 | Resume in throttled mode |
| ledOut | output | 1 | Status LED |

## Verification
The bench checks entry ordering by withholding the SDRAM acknowledge for a few cycles. A design that gated clocks on the start bit alone would show coreClkEn low while selfRefReq is still waiting. It checks wake filtering in depth 3 with an event outside the depth mask and with an event that is globally disabled. A design that ignored either mask would wake early and its clock enables would rise. It times the lock window exactly, from every depth, and records sysRstN during it. An off-by-one counter would change the measured length, and a swapped warm/cold decision would show reset on a light depth or miss it on a deep one. It counts LED edges over a fixed number of ticks to separate the two blink rates, and probes the keep-clock field while asleep in depth 2.

// File: rtl/sleepPkg.sv
package sleepPkg;
  typedef enum logic [2:0] {
    PH_RUN   = 3'd0,
    PH_SRIN  = 3'd1,
    PH_SLEEP = 3'd2,
    PH_LOCK  = 3'd3,
    PH_SROUT = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    DP_NONE = 3'd0,
    DP_SL1  = 3'd1,
    DP_SL2  = 3'd2,
    DP_SL3  = 3'd3,
    DP_SL4  = 3'd4,
    DP_SL5  = 3'd5
  } depth_e;

  // strobes from control to datapath
  typedef struct packed {
    phase_e phase;
    logic   captureDepth;
    logic   loadLock;
    logic   decLock;
    logic   latchThrottle;
  } ctlStrb_t;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_WAKE = 2'd1;
  localparam logic [1:0] ADR_MISC = 2'd2;
  localparam logic [1:0] ADR_LOCK = 2'd3;

  localparam int BIT_GO    = 3;
  localparam int BIT_THROT = 4;
endpackage

// File: rtl/sleepLedGen.sv
module sleepLedGen #(
  parameter int FAST_BIT = 12,
  parameter int SLOW_BIT = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rtcTick,
  input  logic [1:0] ledMode,
  output logic       ledLevel
);
  localparam int CNT_W = SLOW_BIT + 1;

  logic [CNT_W-1:0] divCnt;
  logic unusedDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (rtcTick) divCnt <= divCnt + CNT_W'(1);
  end

  assign unusedDiv = ^divCnt;

  always_comb begin
    case (ledMode)
      2'd0:    ledLevel = 1'b0;
      2'd1:    ledLevel = 1'b1;
      2'd2:    ledLevel = divCnt[SLOW_BIT];
      default: ledLevel = divCnt[FAST_BIT];
    endcase
  end
endmodule

// File: rtl/sleepCtrl.sv
module sleepCtrl
  import sleepPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     goValid,
  input  logic     wakeHit,
  input  logic     lockDone,
  input  logic     srAck,
  output ctlStrb_t strb
);
  phase_e phQ, phD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phQ <= PH_RUN;
    else phQ <= phD;
  end

  always_comb begin
    phD = phQ;
    strb = '0;
    strb.phase = phQ;
    case (phQ)
      PH_RUN: begin
        if (goValid) begin
          strb.captureDepth = 1'b1;
          phD = PH_SRIN;
        end
      end
      PH_SRIN: begin
        if (srAck) phD = PH_SLEEP;
      end
      PH_SLEEP: begin
        if (wakeHit) begin
          strb.loadLock = 1'b1;
          strb.latchThrottle = 1'b1;
          phD = PH_LOCK;
        end
      end
      PH_LOCK: begin
        if (lockDone) phD = PH_SROUT;
        else strb.decLock = 1'b1;
      end
      PH_SROUT: begin
        if (!srAck) phD = PH_RUN;
      end
      default: phD = PH_RUN;
    endcase
  end
endmodule

// File: rtl/sleepDatapath.sv
module sleepDatapath
  import sleepPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int WAKE_W   = 8,
  parameter int KEEP_W   = 4,
  parameter int LOCK_W   = 16,
  parameter int LOCK_RST = 8,
  parameter int FAST_BIT = 12,
  parameter int SLOW_BIT = 14,
  parameter logic [WAKE_W-1:0] MASK_SL1 = '1,
  parameter logic [WAKE_W-1:0] MASK_SL2 = WAKE_W'(8'h7F),
  parameter logic [WAKE_W-1:0] MASK_SL3 = WAKE_W'(8'h0F),
  parameter logic [WAKE_W-1:0] MASK_SL45 = WAKE_W'(8'h03)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              rtcTick,
  input  logic [WAKE_W-1:0] wakeEvt,
  input  ctlStrb_t          strb,
  output logic              goValid,
  output logic              wakeHit,
  output logic              lockDone,
  output logic              coreClkEn,
  output logic              sysClkEn,
  output logic              pllEn,
  output logic [KEEP_W-1:0] keepClkEn,
  output logic              selfRefReq,
  output logic              pwrCtl1,
  output logic              pwrCtl2,
  output logic              onCtlN,
  output logic              sysRstN,
  output logic              throttleOn,
  output logic              ledOut
);
  localparam int KEEP_LO = 4;
  localparam int KEEP_HI = KEEP_LO + KEEP_W - 1;

  depth_e            depthQ;
  logic              throttleEnQ;
  logic              throttleOnQ;
  logic [WAKE_W-1:0] wakeEnQ;
  logic [1:0]        ledModeQ;
  logic [KEEP_W-1:0] keepSelQ;
  logic [LOCK_W-1:0] lockCfgQ;
  logic [LOCK_W-1:0] lockCntQ;
  logic [WAKE_W-1:0] depthMask;
  logic              ledLevel;
  logic              typeOk;
  logic              coldDepth;
  logic              deepOff;
  logic              unusedData;

  assign unusedData = ^regWdata;

  // request decode
  assign typeOk  = (regWdata[2:0] >= 3'd1) && (regWdata[2:0] <= 3'd5);
  assign goValid = regWr && (regAddr == ADR_CTRL) && regWdata[BIT_GO] && typeOk;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      throttleEnQ <= 1'b0;
      wakeEnQ     <= '1;
      ledModeQ    <= 2'd0;
      keepSelQ    <= '0;
      lockCfgQ    <= LOCK_W'(LOCK_RST);
    end else if (regWr) begin
      case (regAddr)
        ADR_CTRL: throttleEnQ <= regWdata[BIT_THROT];
        ADR_WAKE: wakeEnQ <= regWdata[WAKE_W-1:0];
        ADR_MISC: begin
          ledModeQ <= regWdata[1:0];
          keepSelQ <= regWdata[KEEP_HI:KEEP_LO];
        end
        default:  lockCfgQ <= regWdata[LOCK_W-1:0];
      endcase
    end
  end

  // sequencing state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthQ      <= DP_NONE;
      throttleOnQ <= 1'b0;
      lockCntQ    <= '0;
    end else begin
      if (strb.captureDepth) depthQ <= depth_e'(regWdata[2:0]);
      if (strb.latchThrottle) throttleOnQ <= throttleEnQ;
      if (strb.loadLock) lockCntQ <= lockCfgQ;
      else if (strb.decLock) lockCntQ <= lockCntQ - LOCK_W'(1);
    end
  end

  assign lockDone   = (lockCntQ == '0);
  assign throttleOn = throttleOnQ;

  // per-depth wake capability
  always_comb begin
    case (depthQ)
      DP_SL1:         depthMask = MASK_SL1;
      DP_SL2:         depthMask = MASK_SL2;
      DP_SL3:         depthMask = MASK_SL3;
      DP_SL4, DP_SL5: depthMask = MASK_SL45;
      default:        depthMask = '0;
    endcase
  end

  assign wakeHit   = |(wakeEvt & wakeEnQ & depthMask);
  assign coldDepth = (depthQ == DP_SL3) || (depthQ == DP_SL4) || (depthQ == DP_SL5);
  assign deepOff   = (depthQ == DP_SL4) || (depthQ == DP_SL5);

  sleepLedGen #(
    .FAST_BIT(FAST_BIT),
    .SLOW_BIT(SLOW_BIT)
  ) i_led (
    .clk     (clk),
    .rstN    (rstN),
    .rtcTick (rtcTick),
    .ledMode (ledModeQ),
    .ledLevel(ledLevel)
  );

  // output decode per phase and depth
  always_comb begin
    coreClkEn  = 1'b1;
    sysClkEn   = 1'b1;
    pllEn      = 1'b1;
    keepClkEn  = '1;
    selfRefReq = 1'b0;
    pwrCtl1    = 1'b1;
    pwrCtl2    = 1'b1;
    onCtlN     = 1'b0;
    sysRstN    = 1'b1;
    ledOut     = 1'b0;
    case (strb.phase)
      PH_SRIN: selfRefReq = 1'b1;
      PH_SLEEP: begin
        selfRefReq = 1'b1;
        coreClkEn  = 1'b0;
        case (depthQ)
          DP_SL1: ;
          DP_SL2: begin
            sysClkEn  = 1'b0;
            keepClkEn = keepSelQ;
            pllEn     = |keepSelQ;
            pwrCtl1   = 1'b0;
          end
          default: begin
            sysClkEn  = 1'b0;
            keepClkEn = '0;
            pllEn     = 1'b0;
            pwrCtl1   = 1'b0;
            pwrCtl2   = 1'b0;
            onCtlN    = deepOff;
            ledOut    = deepOff & ledLevel;
          end
        endcase
      end
      PH_LOCK: begin
        selfRefReq = 1'b1;
        coreClkEn  = 1'b0;
        sysClkEn   = (depthQ == DP_SL1);
        keepClkEn  = (depthQ == DP_SL1) ? '1 : '0;
        sysRstN    = !coldDepth;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sleepCtl.sv
module sleepCtl
  import sleepPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int WAKE_W   = 8,
  parameter int KEEP_W   = 4,
  parameter int LOCK_W   = 16,
  parameter int LOCK_RST = 8,
  parameter int FAST_BIT = 12,
  parameter int SLOW_BIT = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              rtcTick,
  input  logic [WAKE_W-1:0] wakeEvt,
  input  logic              srAck,
  output logic              coreClkEn,
  output logic              sysClkEn,
  output logic              pllEn,
  output logic [KEEP_W-1:0] keepClkEn,
  output logic              selfRefReq,
  output logic              pwrCtl1,
  output logic              pwrCtl2,
  output logic              onCtlN,
  output logic              sysRstN,
  output logic              throttleOn,
  output logic              ledOut
);
  ctlStrb_t strb;
  logic     goValid;
  logic     wakeHit;
  logic     lockDone;

  sleepCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .goValid (goValid),
    .wakeHit (wakeHit),
    .lockDone(lockDone),
    .srAck   (srAck),
    .strb    (strb)
  );

  sleepDatapath #(
    .DATA_W  (DATA_W),
    .WAKE_W  (WAKE_W),
    .KEEP_W  (KEEP_W),
    .LOCK_W  (LOCK_W),
    .LOCK_RST(LOCK_RST),
    .FAST_BIT(FAST_BIT),
    .SLOW_BIT(SLOW_BIT)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .rtcTick   (rtcTick),
    .wakeEvt   (wakeEvt),
    .strb      (strb),
    .goValid   (goValid),
    .wakeHit   (wakeHit),
    .lockDone  (lockDone),
    .coreClkEn (coreClkEn),
    .sysClkEn  (sysClkEn),
    .pllEn     (pllEn),
    .keepClkEn (keepClkEn),
    .selfRefReq(selfRefReq),
    .pwrCtl1   (pwrCtl1),
    .pwrCtl2   (pwrCtl2),
    .onCtlN    (onCtlN),
    .sysRstN   (sysRstN),
    .throttleOn(throttleOn),
    .ledOut    (ledOut)
  );
endmodule

// File: rtl/sleepCtlChk.sv
module sleepCtlChk (
  input logic clk,
  input logic rstN,
  input logic srAck,
  input logic coreClkEn,
  input logic sysClkEn,
  input logic pllEn,
  input logic selfRefReq,
  input logic pwrCtl1,
  input logic pwrCtl2,
  input logic onCtlN,
  input logic sysRstN,
  input logic ledOut
);
  AST_GATE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreClkEn) |-> $past(srAck)); // R2

  AST_RAIL_NEEDS_SR: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrCtl1 || !pwrCtl2 || onCtlN) |-> selfRefReq); // R6

  AST_PLL_FEEDS_SYS: assert property (@(posedge clk) disable iff (!rstN)
    sysClkEn |-> pllEn); // R5

  AST_CORE_AFTER_SR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreClkEn) |-> !selfRefReq); // R9

  AST_RST_RAILS_UP: assert property (@(posedge clk) disable iff (!rstN)
    !sysRstN |-> (pwrCtl1 && pwrCtl2 && !onCtlN && pllEn && !coreClkEn)); // R10

  AST_LED_DARK: assert property (@(posedge clk) disable iff (!rstN)
    !onCtlN |-> !ledOut); // R12
endmodule

bind sleepCtl sleepCtlChk i_sleepCtlChk (
  .clk       (clk),
  .rstN      (rstN),
  .srAck     (srAck),
  .coreClkEn (coreClkEn),
  .sysClkEn  (sysClkEn),
  .pllEn     (pllEn),
  .selfRefReq(selfRefReq),
  .pwrCtl1   (pwrCtl1),
  .pwrCtl2   (pwrCtl2),
  .onCtlN    (onCtlN),
  .sysRstN   (sysRstN),
  .ledOut    (ledOut)
);

// File: tb/test_sleepCtl.sv
`timescale 1ns/1ps
module test_sleepCtl;
  localparam int DATA_W = 16;
  localparam int WAKE_W = 8;
  localparam int KEEP_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic rtcTick = 1'b0;
  logic [WAKE_W-1:0] wakeEvt = '0;
  logic srAck = 1'b0;
  logic coreClkEn, sysClkEn, pllEn, selfRefReq, pwrCtl1, pwrCtl2, onCtlN, sysRstN;
  logic throttleOn, ledOut;
  logic [KEEP_W-1:0] keepClkEn;

  int nChk = 0;
  int nFail = 0;
  int ackCnt = 0;

  always #4 clk = ~clk;

  sleepCtl #(.FAST_BIT(1), .SLOW_BIT(2)) i_sleepCtl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .rtcTick(rtcTick), .wakeEvt(wakeEvt), .srAck(srAck),
    .coreClkEn(coreClkEn), .sysClkEn(sysClkEn), .pllEn(pllEn), .keepClkEn(keepClkEn),
    .selfRefReq(selfRefReq), .pwrCtl1(pwrCtl1), .pwrCtl2(pwrCtl2), .onCtlN(onCtlN),
    .sysRstN(sysRstN), .throttleOn(throttleOn), .ledOut(ledOut)
  );

  // SDRAM model: acknowledges after the request has been seen on 3 edges
  initial forever begin
    @(posedge clk); #2;
    if (selfRefReq) ackCnt++; else ackCnt = 0;
    srAck = selfRefReq && (ackCnt >= 3);
  end

  // 32 kHz tick: one pulse every 4 cycles
  initial forever begin
    repeat (3) @(negedge clk);
    rtcTick = 1'b1;
    @(negedge clk);
    rtcTick = 1'b0;
  end

  function automatic int outVec();
    return {coreClkEn, sysClkEn, pllEn, selfRefReq, pwrCtl1, pwrCtl2, onCtlN, sysRstN};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic waitAsleep();
    for (int i = 0; i < 30 && coreClkEn; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic waitRun();
    for (int i = 0; i < 30 && (selfRefReq || srAck); i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // pulse one wake bit, measure edges until coreClkEn returns
  task automatic wakeTimed(input string req, input int bitIdx, input int expLen,
                           input logic expRstSeen);
    int cnt;
    logic rstSeen;
    cnt = 0;
    rstSeen = 1'b0;
    @(negedge clk);
    wakeEvt = WAKE_W'(1) << bitIdx;
    do begin
      @(negedge clk);
      wakeEvt = '0;
      cnt++;
      if (!sysRstN) rstSeen = 1'b1;
    end while (!coreClkEn && cnt < 40);
    chk("R9", {req, " lock window length"}, cnt, expLen);
    chk("R10", {req, " reset seen in window"}, int'(rstSeen), int'(expRstSeen));
    chk("R9", {req, " self-refresh dropped"}, int'(selfRefReq), 0);
    waitRun();
  endtask

  task automatic t_reset();
    chk("R1", "reset outputs", outVec(), 8'hED);
    chk("R1", "reset keep", int'(keepClkEn), 4'hF);
    chk("R1", "reset led/throttle", int'({ledOut, throttleOn}), 0);
  endtask

  task automatic t_invalid();
    wrReg(2'd0, 16'h0008);          // code 0
    repeat (3) @(negedge clk);
    chk("R3", "code 0 ignored", outVec(), 8'hED);
    wrReg(2'd0, 16'h000E);          // code 6
    repeat (3) @(negedge clk);
    chk("R3", "code 6 ignored", outVec(), 8'hED);
    wrReg(2'd0, 16'h000F);          // code 7
    repeat (3) @(negedge clk);
    chk("R3", "code 7 ignored", outVec(), 8'hED);
    wrReg(2'd0, 16'h0001);          // start bit clear
    repeat (3) @(negedge clk);
    chk("R3", "no start bit", outVec(), 8'hED);
  endtask

  task automatic t_sl1();
    wrReg(2'd3, 16'd5);             // R13 lock count
    wrReg(2'd0, 16'h0009);
    chk("R2", "request raised, clock on", int'({selfRefReq, coreClkEn}), 2'b11);
    @(negedge clk);
    chk("R2", "clock held until ack", int'({selfRefReq, coreClkEn}), 2'b11);
    waitAsleep();
    chk("R4", "depth 1 outputs", outVec(), 8'h7D);
    chk("R4", "depth 1 keep", int'(keepClkEn), 4'hF);
    wakeTimed("R9 depth1", 7, 7, 1'b0);
    chk("R11", "throttle off", int'(throttleOn), 0);
    chk("R1", "back to run", outVec(), 8'hED);
  endtask

  task automatic t_sl2();
    wrReg(2'd2, 16'h0050);          // keep 0101, led off
    wrReg(2'd0, 16'h000A);
    waitAsleep();
    chk("R5", "depth 2 outputs", outVec(), 8'h35);
    chk("R5", "depth 2 keep", int'(keepClkEn), 4'h5);
    wrReg(2'd2, 16'h0000);
    @(negedge clk);
    chk("R5", "keep cleared asleep", outVec(), 8'h15);
    chk("R5", "keep bits zero", int'(keepClkEn), 0);
    wakeTimed("R9 depth2", 6, 7, 1'b0);
  endtask

  task automatic t_sl3();
    wrReg(2'd0, 16'h001B);          // depth 3, throttle on
    waitAsleep();
    chk("R6", "depth 3 outputs", outVec(), 8'h11);
    @(negedge clk); wakeEvt = 8'h20; @(negedge clk); wakeEvt = '0;
    repeat (8) @(negedge clk);
    chk("R8", "bit 5 outside depth mask", outVec(), 8'h11);
    wrReg(2'd1, 16'h00F7);
    @(negedge clk); wakeEvt = 8'h08; @(negedge clk); wakeEvt = '0;
    repeat (8) @(negedge clk);
    chk("R8", "bit 3 globally disabled", outVec(), 8'h11);
    wakeTimed("R8 depth3 bit2", 2, 7, 1'b1);
    chk("R11", "throttle latched on", int'(throttleOn), 1);
    wrReg(2'd1, 16'h00FF);
  endtask

  task automatic t_deep(input int code, input int wakeBit);
    int edges;
    logic prev;
    wrReg(2'd2, 16'h0001);          // led on
    wrReg(2'd0, 16'(code | 8));     // throttle off
    waitAsleep();
    chk("R7", $sformatf("depth %0d outputs", code), outVec(), 8'h13);
    chk("R12", "led steady on", int'(ledOut), 1);
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      wrReg(2'd2, 16'(m));
      repeat (3) @(negedge clk);
      edges = 0;
      prev = ledOut;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        if (ledOut !== prev) edges++;
        prev = ledOut;
      end
      chk("R12", $sformatf("led mode %0d edges", m), edges, (m == 0) ? 0 : (m == 2) ? 4 : 8);
    end
    wrReg(2'd2, 16'h0000);
    wakeTimed("R7 deep", wakeBit, 7, 1'b1);
    chk("R11", "throttle cleared", int'(throttleOn), 0);
    chk("R12", "led dark in run", int'(ledOut), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_invalid();
    t_sl1();
    t_sl2();
    t_sl3();
    t_deep(4, 0);
    t_deep(5, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule